// File: doc/BRIEF.md
# Interrupt Steering Aggregator

This block gathers a wide vector of level-sensitive interrupt requests and folds them onto a handful of summary lines, one line for every block of 64 inputs. Software reaches it through a small word-wide register bus. Through that bus it can:

- enable or block each input;
- force any input pending from software;
- read back which enabled inputs are pending;
- silence a whole summary line without touching the per-input enables;
- pick which destination channel or channels the summary lines drive.

The register banks are laid out with a stride that grows with the input count. Inside each bank the words are ordered from the highest input group down, so word 0 of a bank always covers the top 32 inputs.

Reads are combinational: `bus_rdata` follows `bus_addr` in the same cycle. A write completes on the clock edge where `bus_we` is high. Summary lines are registered, so they follow the inputs and the registers one clock later.

Top module: `irq_steer_agg`

## Requirements
- R1: With W = NUM_IN/32 words per bank, word r of the enable, force and status banks covers inputs (W-1-r)*32 to (W-1-r)*32+31, and input n sits at bit n mod 32 of its word.
- R2: Byte addresses are decoded exactly. S = 4*W. The map is:
  - channel select at 0x0;
  - enable word r at 0x4+4r;
  - force word r at S+0x4+4r;
  - status word r at 2S+0x4+4r;
  - line disable at 3S+0x4;
  - line summary at 3S+0x8.
- R3: An enable bit of 1 lets its input through, and an enable bit of 0 blocks it. Enable words read back as written.
- R4: Line k (k = 0 .. ceil(NUM_IN/64)-1) is high one clock after any enabled pending input in 64k..64k+63 is present. It stays high while that input stays pending, and drops one clock after none is left.
- R5: Force bits are read/write. A force bit of 1 makes its input pending until software writes it back to 0.
- R6: Each status bit reads (input OR force bit) AND enable bit. A write to a status address changes no register.
- R7: Bit k of the line summary word is the OR of the enabled pending inputs of group k, whatever the disable bits hold. The upper bits read 0.
- R8: A 1 in bit k of the line disable word holds line k low one clock later and leaves the enable bits unchanged. The disable word reads back as written.
- R9: Bit c of the channel select word routes every line k to `chan_irq[c*NUM_OUT+k]`. Channels whose bit is 0 stay low. The word reads back its low NUM_CHAN bits.
- R10: While `rst_n` is low at a clock edge, all enable, force, disable and channel select bits clear, and every `chan_irq` bit is 0 after that edge.
- R11: Reads of unmapped or misaligned addresses return 0, and writes to them change no register.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| irq_in | input | NUM_IN | Level-sensitive interrupt requests, already synchronous to clk |
| bus_addr | input | ADDR_W | Byte address of the register access |
| bus_we | input | 1 | Write strobe, captured on the rising clock edge |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data for bus_addr, combinational |
| chan_irq | output | NUM_CHAN*NUM_OUT | Summary lines per channel, channel c at bits c*NUM_OUT upward |

## Verification
The bound checker watches, on every cycle:
- that no summary line rises unless some enabled pending input of its group was present the cycle before;
- that a disabled line stays low;
- that writes to status or unmapped addresses leave every register untouched;
- that unmapped and misaligned reads return zero;
- that reset silences the lines.

The reversed word order, the exact bit position of each input, the read-back of each bank and the routing to each channel depend on specific values. Only the bench's sweeps can show them. Those sweeps walk one input, one enable bit and one force bit at a time across the whole vector and compare against arithmetic expectations.

// File: rtl/irq_steer_pkg.sv
// Package: shared register-select type and address decode for the
// interrupt steering aggregator.
// Assumes byte addressing with 32-bit words; misaligned addresses decode
// to no register.
package irq_steer_pkg;

    typedef enum logic [2:0] {
        RK_NONE,
        RK_CHSEL,
        RK_ENABLE,
        RK_FORCE,
        RK_STATUS,
        RK_LDIS,
        RK_LSUM
    } reg_kind_e;

    typedef struct packed {
        reg_kind_e  kind;
        logic [7:0] idx;
    } reg_sel_t;

    // Map a byte address onto a bank and a word index; words is the bank depth.
    function automatic reg_sel_t decode_addr(input logic [31:0] addr,
                                             input int unsigned words);
        reg_sel_t    s;
        logic [31:0] stride;
        stride = 32'(4 * words);
        s.kind = RK_NONE;
        s.idx  = '0;
        if (addr[1:0] == 2'b00) begin
            if (addr == 32'd0) begin
                s.kind = RK_CHSEL;
            end else if (addr >= 32'd4 && addr < stride + 32'd4) begin
                s.kind = RK_ENABLE;
                s.idx  = 8'((addr - 32'd4) >> 2);
            end else if (addr >= stride + 32'd4 && addr < 2 * stride + 32'd4) begin
                s.kind = RK_FORCE;
                s.idx  = 8'((addr - stride - 32'd4) >> 2);
            end else if (addr >= 2 * stride + 32'd4 && addr < 3 * stride + 32'd4) begin
                s.kind = RK_STATUS;
                s.idx  = 8'((addr - 2 * stride - 32'd4) >> 2);
            end else if (addr == 3 * stride + 32'd4) begin
                s.kind = RK_LDIS;
            end else if (addr == 3 * stride + 32'd8) begin
                s.kind = RK_LSUM;
            end
        end
        return s;
    endfunction

endpackage

// File: rtl/irq_steer_regs.sv
// Module: software-writable state of the aggregator (channel select,
// per-input enables, per-input force bits, per-line disables).
// Assumes NUM_IN is a multiple of 32; bank word r holds the inputs of
// group (WORDS-1-r), so the top inputs sit in word 0.
module irq_steer_regs
    import irq_steer_pkg::*;
#(
    parameter int NUM_IN   = 128,
    parameter int NUM_CHAN = 4,
    parameter int NUM_OUT  = 2
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                wr_en,
    input  reg_sel_t            sel,
    input  logic [31:0]         wdata,
    output logic [NUM_CHAN-1:0] chsel_q,
    output logic [NUM_IN-1:0]   enable_q,
    output logic [NUM_IN-1:0]   force_q,
    output logic [NUM_OUT-1:0]  ldis_q
);
    localparam int WORDS = NUM_IN / 32;

    // Capture bus writes into the addressed register; reset clears all.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            chsel_q  <= '0;
            enable_q <= '0;
            force_q  <= '0;
            ldis_q   <= '0;
        end else if (wr_en) begin
            case (sel.kind)
                RK_CHSEL: chsel_q <= wdata[NUM_CHAN-1:0];
                RK_LDIS:  ldis_q  <= wdata[NUM_OUT-1:0];
                RK_ENABLE: begin
                    for (int r = 0; r < WORDS; r++) begin
                        if (sel.idx == 8'(r)) enable_q[(WORDS-1-r)*32 +: 32] <= wdata;
                    end
                end
                RK_FORCE: begin
                    for (int r = 0; r < WORDS; r++) begin
                        if (sel.idx == 8'(r)) force_q[(WORDS-1-r)*32 +: 32] <= wdata;
                    end
                end
                default: ;
            endcase
        end
    end
endmodule

// File: rtl/irq_steer_groups.sv
// Module: combines inputs and force bits under the enables, ORs them per
// group of 64 and registers the summary lines after the line disables.
// Assumes irq_in is already synchronous to clk; a last partial group
// covers only the inputs that exist.
module irq_steer_groups #(
    parameter int NUM_IN  = 128,
    parameter int NUM_OUT = 2
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic [NUM_IN-1:0]  irq_in,
    input  logic [NUM_IN-1:0]  enable_q,
    input  logic [NUM_IN-1:0]  force_q,
    input  logic [NUM_OUT-1:0] ldis_q,
    output logic [NUM_IN-1:0]  pend,
    output logic [NUM_OUT-1:0] grp_act,
    output logic [NUM_OUT-1:0] out_q
);
    // Enabled pending inputs: raw level or software force, gated by enable.
    assign pend = (irq_in | force_q) & enable_q;

    for (genvar k = 0; k < NUM_OUT; k++) begin : g_grp
        localparam int LO = k * 64;
        localparam int HI = (LO + 64 > NUM_IN) ? NUM_IN - 1 : LO + 63;
        // One summary bit per group of up to 64 inputs.
        assign grp_act[k] = |pend[HI:LO];
    end

    // Register the lines, masked by the per-line disables.
    always_ff @(posedge clk) begin
        if (!rst_n) out_q <= '0;
        else        out_q <= grp_act & ~ldis_q;
    end
endmodule

// File: rtl/irq_steer_rdmux.sv
// Module: combinational read-data selection for the register bus.
// Assumes the select comes from the shared decode; unmapped reads give 0.
module irq_steer_rdmux
    import irq_steer_pkg::*;
#(
    parameter int NUM_IN   = 128,
    parameter int NUM_CHAN = 4,
    parameter int NUM_OUT  = 2
) (
    input  reg_sel_t            sel,
    input  logic [NUM_CHAN-1:0] chsel_q,
    input  logic [NUM_IN-1:0]   enable_q,
    input  logic [NUM_IN-1:0]   force_q,
    input  logic [NUM_IN-1:0]   pend,
    input  logic [NUM_OUT-1:0]  ldis_q,
    input  logic [NUM_OUT-1:0]  grp_act,
    output logic [31:0]         rdata
);
    localparam int WORDS = NUM_IN / 32;

    // Pick the addressed word, reversing the word order of the banks.
    always_comb begin
        rdata = '0;
        case (sel.kind)
            RK_CHSEL: rdata = 32'(chsel_q);
            RK_LDIS:  rdata = 32'(ldis_q);
            RK_LSUM:  rdata = 32'(grp_act);
            RK_ENABLE, RK_FORCE, RK_STATUS: begin
                for (int r = 0; r < WORDS; r++) begin
                    if (sel.idx == 8'(r)) begin
                        if (sel.kind == RK_ENABLE)     rdata = enable_q[(WORDS-1-r)*32 +: 32];
                        else if (sel.kind == RK_FORCE) rdata = force_q[(WORDS-1-r)*32 +: 32];
                        else                           rdata = pend[(WORDS-1-r)*32 +: 32];
                    end
                end
            end
            default: rdata = '0;
        endcase
    end
endmodule

// File: rtl/irq_steer_agg.sv
// Module: top of the interrupt steering aggregator. Decodes the register
// bus, holds the software state, forms one summary line per 64 inputs and
// routes the lines to the channels whose select bit is set.
// Assumes NUM_IN is a multiple of 32 with at most 8 lines, and ADDR_W is
// wide enough for 3*(NUM_IN/8)+8.
module irq_steer_agg
    import irq_steer_pkg::*;
#(
    parameter int NUM_IN   = 128,
    parameter int NUM_CHAN = 4,
    parameter int ADDR_W   = 8,
    localparam int NUM_OUT = (NUM_IN + 63) / 64
) (
    input  logic                         clk,
    input  logic                         rst_n,
    input  logic [NUM_IN-1:0]            irq_in,
    input  logic [ADDR_W-1:0]            bus_addr,
    input  logic                         bus_we,
    input  logic [31:0]                  bus_wdata,
    output logic [31:0]                  bus_rdata,
    output logic [NUM_CHAN*NUM_OUT-1:0]  chan_irq
);
    localparam int WORDS = NUM_IN / 32;

    reg_sel_t            sel;
    logic [NUM_CHAN-1:0] chsel_q;
    logic [NUM_IN-1:0]   enable_q;
    logic [NUM_IN-1:0]   force_q;
    logic [NUM_OUT-1:0]  ldis_q;
    logic [NUM_IN-1:0]   pend;
    logic [NUM_OUT-1:0]  grp_act;
    logic [NUM_OUT-1:0]  out_q;

    // Shared decode for both the write and the read path.
    assign sel = decode_addr(32'(bus_addr), WORDS);

    irq_steer_regs #(.NUM_IN(NUM_IN), .NUM_CHAN(NUM_CHAN), .NUM_OUT(NUM_OUT)) u_regs (
        .clk(clk), .rst_n(rst_n), .wr_en(bus_we), .sel(sel), .wdata(bus_wdata),
        .chsel_q(chsel_q), .enable_q(enable_q), .force_q(force_q), .ldis_q(ldis_q)
    );

    irq_steer_groups #(.NUM_IN(NUM_IN), .NUM_OUT(NUM_OUT)) u_groups (
        .clk(clk), .rst_n(rst_n), .irq_in(irq_in), .enable_q(enable_q),
        .force_q(force_q), .ldis_q(ldis_q), .pend(pend), .grp_act(grp_act),
        .out_q(out_q)
    );

    irq_steer_rdmux #(.NUM_IN(NUM_IN), .NUM_CHAN(NUM_CHAN), .NUM_OUT(NUM_OUT)) u_rdmux (
        .sel(sel), .chsel_q(chsel_q), .enable_q(enable_q), .force_q(force_q),
        .pend(pend), .ldis_q(ldis_q), .grp_act(grp_act), .rdata(bus_rdata)
    );

    for (genvar c = 0; c < NUM_CHAN; c++) begin : g_chan
        // Channel c carries every line when its select bit is set.
        assign chan_irq[c*NUM_OUT +: NUM_OUT] = out_q & {NUM_OUT{chsel_q[c]}};
    end
endmodule

// File: rtl/irq_steer_chk.sv
// Module: property checker for the aggregator, bound to the top.
// Assumes the synchronous active-low reset of the top.
module irq_steer_chk #(
    parameter int NUM_IN   = 128,
    parameter int NUM_CHAN = 4,
    parameter int ADDR_W   = 8,
    parameter int NUM_OUT  = 2
) (
    input logic                        clk,
    input logic                        rst_n,
    input logic [NUM_IN-1:0]           irq_in,
    input logic [ADDR_W-1:0]           bus_addr,
    input logic                        bus_we,
    input logic [31:0]                 bus_rdata,
    input logic [NUM_CHAN*NUM_OUT-1:0] chan_irq,
    input logic [NUM_CHAN-1:0]         chsel_q,
    input logic [NUM_IN-1:0]           enable_q,
    input logic [NUM_IN-1:0]           force_q,
    input logic [NUM_OUT-1:0]          ldis_q
);
    localparam int STRIDE = NUM_IN / 8;
    localparam logic [ADDR_W-1:0] STAT_LO = ADDR_W'(2 * STRIDE + 4);
    localparam logic [ADDR_W-1:0] STAT_HI = ADDR_W'(3 * STRIDE + 4);
    localparam logic [ADDR_W-1:0] MAP_END = ADDR_W'(3 * STRIDE + 12);

    logic no_effect_addr;
    assign no_effect_addr = (bus_addr[1:0] != 2'b00) || (bus_addr >= MAP_END) ||
                            (bus_addr >= STAT_LO && bus_addr < STAT_HI);

    // R10
    reset_quiet_chk: assert property (@(posedge clk) !rst_n |=> chan_irq == '0);

    // R11
    unmapped_read_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ((bus_addr[1:0] != 2'b00) || (bus_addr >= MAP_END)) |-> bus_rdata == '0);

    // R6 R11
    no_effect_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_we && no_effect_addr) |=>
            ($stable(enable_q) && $stable(force_q) && $stable(chsel_q) && $stable(ldis_q)));

    for (genvar k = 0; k < NUM_OUT; k++) begin : g_line
        localparam int LO = k * 64;
        localparam int HI = (LO + 64 > NUM_IN) ? NUM_IN - 1 : LO + 63;
        for (genvar c = 0; c < NUM_CHAN; c++) begin : g_ch
            // R8
            disable_forces_low_chk: assert property (@(posedge clk) disable iff (!rst_n)
                $past(ldis_q[k]) |-> !chan_irq[c*NUM_OUT+k]);
            // R4
            line_needs_pending_chk: assert property (@(posedge clk) disable iff (!rst_n)
                chan_irq[c*NUM_OUT+k] |-> $past(|((irq_in[HI:LO] | force_q[HI:LO]) & enable_q[HI:LO])));
        end
    end
endmodule

bind irq_steer_agg irq_steer_chk #(
    .NUM_IN(NUM_IN), .NUM_CHAN(NUM_CHAN), .ADDR_W(ADDR_W), .NUM_OUT(NUM_OUT)
) u_chk (
    .clk(clk), .rst_n(rst_n), .irq_in(irq_in), .bus_addr(bus_addr), .bus_we(bus_we),
    .bus_rdata(bus_rdata), .chan_irq(chan_irq), .chsel_q(chsel_q),
    .enable_q(enable_q), .force_q(force_q), .ldis_q(ldis_q)
);

// File: tb/sim_irq_steer_agg.sv
// Bench: sweeps single inputs, single enable bits and single force bits over
// a 128-input, 4-channel configuration and compares against arithmetic
// expectations built from the requirements.
module sim_irq_steer_agg;
    localparam int NI = 128;
    localparam int NC = 4;
    localparam int AW = 8;
    localparam int NO = 2;
    localparam int WD = NI / 32;
    localparam int S  = 4 * WD;

    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic [NI-1:0]     irq_in = '0;
    logic [AW-1:0]     bus_addr = '0;
    logic              bus_we = 1'b0;
    logic [31:0]       bus_wdata = '0;
    logic [31:0]       bus_rdata;
    logic [NC*NO-1:0]  chan_irq;

    int vectors = 0;
    int misses  = 0;

    logic [NI-1:0] m_en = '0;
    logic [NI-1:0] m_frc = '0;
    logic [NC-1:0] m_sel = '0;
    logic [NO-1:0] m_dis = '0;

    irq_steer_agg #(.NUM_IN(NI), .NUM_CHAN(NC), .ADDR_W(AW)) u0 (
        .clk(clk), .rst_n(rst_n), .irq_in(irq_in), .bus_addr(bus_addr),
        .bus_we(bus_we), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
        .chan_irq(chan_irq)
    );

    always #10 clk = ~clk;

    function automatic int a_en(int r);  return 4 + 4 * r;         endfunction
    function automatic int a_frc(int r); return S + 4 + 4 * r;     endfunction
    function automatic int a_st(int r);  return 2 * S + 4 + 4 * r; endfunction
    localparam int A_DIS = 3 * S + 4;
    localparam int A_SUM = 3 * S + 8;

    function automatic logic [NI-1:0] m_pend();
        return (irq_in | m_frc) & m_en;
    endfunction

    function automatic logic [NO-1:0] m_grp();
        logic [NI-1:0] p;
        logic [NO-1:0] g;
        p = m_pend();
        for (int k = 0; k < NO; k++) g[k] = |p[k*64 +: 64];
        return g;
    endfunction

    function automatic logic [NC*NO-1:0] m_chan();
        logic [NC*NO-1:0] e;
        logic [NO-1:0]    ln;
        ln = m_grp() & ~m_dis;
        for (int c = 0; c < NC; c++) e[c*NO +: NO] = m_sel[c] ? ln : '0;
        return e;
    endfunction

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        vectors++;
        if (act !== exp) begin
            misses++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    task automatic wr(input int a, input logic [31:0] d);
        @(negedge clk);
        bus_addr = AW'(a); bus_wdata = d; bus_we = 1'b1;
        @(negedge clk);
        bus_we = 1'b0;
    endtask

    task automatic rd(input int a, output logic [31:0] d);
        @(negedge clk);
        bus_addr = AW'(a);
        #2 d = bus_rdata;
    endtask

    task automatic settle();
        @(posedge clk);
        #5;
    endtask

    task automatic set_en(input int r, input logic [31:0] v);
        wr(a_en(r), v);
        m_en[(WD-1-r)*32 +: 32] = v;
    endtask

    task automatic set_frc(input int r, input logic [31:0] v);
        wr(a_frc(r), v);
        m_frc[(WD-1-r)*32 +: 32] = v;
    endtask

    task automatic chk_regs(input string req);
        logic [31:0] d;
        rd(0, d);     chk(req, d, 32'(m_sel));
        rd(A_DIS, d); chk(req, d, 32'(m_dis));
        for (int r = 0; r < WD; r++) begin
            rd(a_en(r), d);  chk(req, d, m_en[(WD-1-r)*32 +: 32]);
            rd(a_frc(r), d); chk(req, d, m_frc[(WD-1-r)*32 +: 32]);
        end
    endtask

    initial begin
        #(20 * 150000);
        misses++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("== %0d vectors applied, %0d miscompares ==", vectors, misses);
        $finish;
    end

    initial begin
        logic [31:0] d;
        int n, r;
        // R10: reset state, inputs all high but nothing enabled
        irq_in = '1;
        repeat (3) @(posedge clk);
        #5 rst_n = 1'b1;
        settle();
        chk("R10 lines after reset", 32'(chan_irq), 32'(0));
        chk_regs("R10 registers after reset");
        for (int q = 0; q < WD; q++) begin
            rd(a_st(q), d); chk("R10 status after reset", d, 32'(0));
        end

        // R1 R2 R4 R6 R7: walk one input with everything enabled, channel 0
        wr(0, 32'h1); m_sel = 4'h1;
        for (int q = 0; q < WD; q++) set_en(q, 32'hFFFF_FFFF);
        for (int i = 0; i < NI; i++) begin
            irq_in = '0; irq_in[i] = 1'b1;
            settle();
            chk("R4 line per group", 32'(chan_irq), 32'(m_chan()));
            r = WD - 1 - i / 32;
            rd(a_st(r), d); chk("R1 R6 status position", d, 32'(1) << (i % 32));
            rd(A_SUM, d);   chk("R7 line summary", d, 32'(1) << (i / 64));
        end
        // R4: line drops one clock after the input goes away
        irq_in = '0;
        settle();
        chk("R4 line drop", 32'(chan_irq), 32'(0));

        // R3: all inputs high, one enable bit at a time
        irq_in = '1;
        for (int q = 0; q < WD; q++) set_en(q, 32'h0);
        settle();
        chk("R3 all blocked", 32'(chan_irq), 32'(0));
        for (int i = 0; i < NI; i += 3) begin
            r = WD - 1 - i / 32;
            set_en(r, 32'(1) << (i % 32));
            settle();
            chk("R3 single enable", 32'(chan_irq), 32'(m_chan()));
            rd(a_en(r), d); chk("R3 R2 enable readback", d, 32'(1) << (i % 32));
            set_en(r, 32'h0);
        end

        // R5: inputs low, one force bit at a time
        irq_in = '0;
        for (int q = 0; q < WD; q++) set_en(q, 32'hFFFF_FFFF);
        for (int i = 1; i < NI; i += 7) begin
            r = WD - 1 - i / 32;
            set_frc(r, 32'(1) << (i % 32));
            settle();
            chk("R5 forced line", 32'(chan_irq), 32'(m_chan()));
            rd(a_st(r), d);  chk("R5 forced status", d, 32'(1) << (i % 32));
            rd(a_frc(r), d); chk("R5 R2 force readback", d, 32'(1) << (i % 32));
            set_frc(r, 32'h0);
            settle();
            chk("R5 force cleared", 32'(chan_irq), 32'(0));
        end
        // R5 R3: forced but disabled input stays blocked
        set_en(WD - 1, 32'h0);
        set_frc(WD - 1, 32'h0000_0010);
        settle();
        chk("R5 forced but blocked", 32'(chan_irq), 32'(0));
        set_frc(WD - 1, 32'h0);
        set_en(WD - 1, 32'hFFFF_FFFF);

        // R6: write to a status word changes nothing
        irq_in = '0; irq_in[100] = 1'b1;
        set_en(0, 32'h0000_0030);
        wr(a_st(0), 32'hFFFF_FFFF);
        chk_regs("R6 status write ignored");
        rd(a_st(0), d); chk("R6 status after write", d, 32'h0000_0010);
        set_en(0, 32'hFFFF_FFFF);

        // R8 R7: disable line 0 with both groups pending
        irq_in = '0; irq_in[5] = 1'b1; irq_in[100] = 1'b1;
        wr(A_DIS, 32'h1); m_dis = 2'b01;
        settle();
        chk("R8 line 0 held low", 32'(chan_irq), 32'(m_chan()));
        rd(A_SUM, d); chk("R7 summary ignores disable", d, 32'h3);
        chk_regs("R8 enables and disable readback");
        wr(A_DIS, 32'h0); m_dis = '0;
        settle();
        chk("R8 line 0 back", 32'(chan_irq), 32'(m_chan()));

        // R9: route to each channel, all, none
        for (int c = 0; c < NC; c++) begin
            wr(0, 32'(1) << c); m_sel = NC'(1) << c;
            settle();
            chk("R9 channel route", 32'(chan_irq), 32'(m_chan()));
        end
        wr(0, 32'hFFFF_FFFF); m_sel = '1;
        settle();
        chk("R9 all channels", 32'(chan_irq), 32'(m_chan()));
        rd(0, d); chk("R9 select readback", d, 32'hF);
        wr(0, 32'h0); m_sel = '0;
        settle();
        chk("R9 no channel", 32'(chan_irq), 32'(0));
        wr(0, 32'h2); m_sel = 4'h2;

        // R11: unmapped and misaligned reads and writes
        rd(3 * S + 12, d); chk("R11 read past map", d, 32'(0));
        rd(8'hFC, d);      chk("R11 read top", d, 32'(0));
        rd(5, d);          chk("R11 misaligned read", d, 32'(0));
        rd(S + 6, d);      chk("R11 misaligned force read", d, 32'(0));
        wr(3 * S + 12, 32'hFFFF_FFFF);
        wr(6, 32'h0);
        wr(S + 5, 32'hFFFF_FFFF);
        chk_regs("R11 write ignored");

        // R10: reset mid-run clears everything
        set_frc(1, 32'h0000_0F00);
        wr(A_DIS, 32'h2); m_dis = 2'b10;
        @(negedge clk); rst_n = 1'b0;
        @(posedge clk); #5;
        chk("R10 lines in reset", 32'(chan_irq), 32'(0));
        @(negedge clk); rst_n = 1'b1;
        m_en = '0; m_frc = '0; m_sel = '0; m_dis = '0;
        settle();
        chk_regs("R10 registers after second reset");
        chk("R10 lines after second reset", 32'(chan_irq), 32'(0));

        n = 0;
        r = n;
        $display("== %0d vectors applied, %0d miscompares ==", vectors, misses);
        $finish;
    end
endmodule